// File: doc/BRIEF.md
# Six-Channel DMA Burst Arbiter

This block chooses which of six DMA channels the shared transfer engine serves next. A channel can be chosen only when its request line and its enable line are both high. The engine reports progress through two strobes. `word_done_i` marks the end of each word. `burst_done_i` marks the last word of a burst and always comes together with `word_done_i`. The arbiter answers with a registered one-hot grant.

In the fair mode every channel has equal weight. After a burst, the search for the next channel starts at the channel after the one just served and wraps from channel 6 back to channel 1.

When `hp_mode_i` is set, channel 1 wins every burst boundary at which it is eligible. It can also take the engine at any word boundary inside another channel's burst. The interrupted channel is kept aside while channel 1 runs one full burst. After that burst there is one idle cycle, and then the interrupted channel gets the grant back and finishes its burst.

A priority-reset command moves the fair-order search back to channel 1. It waits for the burst in progress to finish before it does so.

Top module: `dma_prio_arb`

## Requirements
- R1: `grant_o` has at most one bit set. Bit k stands for channel k+1. A grant that starts from the idle state (no grant in the previous cycle, `resume_o` low) goes to a channel whose request and enable were both high in the previous cycle. When no channel is eligible, `grant_o` is zero.
- R2: With `hp_mode_i` low, each burst boundary searches upward from the channel after the one just served and wraps from channel 6 to channel 1. The new grant appears in the cycle right after the boundary, with no gap.
- R3: A grant stays unchanged until the engine reports the end of a burst, except for a channel-1 pre-emption at a word boundary.
- R4: With `hp_mode_i` low, channel 1 never pre-empts another channel. With `hp_mode_i` high, an eligible channel 1 wins every arbitration, whatever the fair-order position.
- R5: With `hp_mode_i` high and channel 1 eligible, a `word_done_i` without `burst_done_i` on another channel moves the grant to channel 1 in the next cycle. `preempt_o` is high in exactly that cycle.
- R6: Channel 1 never pre-empts itself. While it holds the grant, its grant lasts until its own `burst_done_i`.
- R7: When the pre-empting channel-1 burst ends, `grant_o` is zero for one cycle. In the following cycle the interrupted channel is granted again and `resume_o` is high, whatever its request line shows.
- R8: A pre-empting channel-1 burst does not move the fair-order position. The next search after the resumed burst starts at the channel after the resumed one.
- R9: A `prio_rst_i` pulse during a burst is held until that burst ends. The arbitration at that boundary then starts its search at channel 1. When no grant is active, the reset applies at once.
- R10: After `rst_n` is released, `grant_o`, `preempt_o` and `resume_o` are zero, and the first search starts at channel 1.
- R11: `word_done_i` and `burst_done_i` have no effect while no channel is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_req_i | input | 6 | Per-channel request, bit k = channel k+1 |
| ch_en_i | input | 6 | Per-channel enable, bit k = channel k+1 |
| word_done_i | input | 1 | Engine finished a word of the granted channel |
| burst_done_i | input | 1 | Engine finished the last word of the burst |
| hp_mode_i | input | 1 | 1 = channel 1 has top priority and may pre-empt |
| prio_rst_i | input | 1 | Return the fair order to channel 1 at the next burst boundary |
| grant_o | output | 6 | One-hot grant, zero when idle |
| preempt_o | output | 1 | High in the first cycle of a pre-empting channel-1 grant |
| resume_o | output | 1 | High in the cycle an interrupted channel is granted again |

## Verification
The fair-order search is swept over all 4096 combinations of request and enable vectors, in both priority modes, using one-word bursts. Each sweep starts from a priority reset, and eight successive grants are compared with a rotating search worked out arithmetically. This separates wrap-around errors, an off-by-one start position and masking by the enable lines, and it shows that channel 1 dominates only in the high-priority mode. A directed sequence with multi-word bursts then checks the order of events around a pre-emption: the word-boundary take-over, the refusal to pre-empt channel 1 itself, the one idle cycle, the resumed channel, and a fair-order position that the pre-emption did not move. The same sequence checks that a priority reset waits for the end of the current burst.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
   typedef enum logic [1:0] {
      ARB_IDLE = 2'd0,
      ARB_BUSY = 2'd1,
      ARB_GAP  = 2'd2
   } arb_st_e;
endpackage

// File: rtl/dma_arb_rr_pick.sv
// Rotating-priority search: the first set bit of elig at or after start, wrapping.
module dma_arb_rr_pick #(
   parameter int N_CH = 6,
   localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic [N_CH-1:0] elig,
   input  logic [IW-1:0]   start,
   output logic            found,
   output logic [IW-1:0]   idx
);
   int            cand;
   logic [IW-1:0] cand_ix;

   always_comb begin
      found   = 1'b0;
      idx     = '0;
      cand    = 0;
      cand_ix = '0;
      // Walk from the farthest offset down to zero so the nearest hit wins.
      for (int k = N_CH - 1; k >= 0; k--) begin
         cand = int'(start) + k;
         if (cand >= N_CH) cand = cand - N_CH;
         cand_ix = IW'(cand);
         if (elig[cand_ix]) begin
            found = 1'b1;
            idx   = cand_ix;
         end
      end
   end
endmodule

// File: rtl/dma_arb_ctx.sv
// Holds the channel suspended by a pre-emption until it is resumed.
module dma_arb_ctx #(
   parameter int N_CH = 6,
   localparam int IW = (N_CH > 1) ? $clog2(N_CH) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          save,
   input  logic          restore,
   input  logic [IW-1:0] ch_in,
   output logic          vld,
   output logic [IW-1:0] ch
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld <= 1'b0;
         ch  <= '0;
      end else if (save) begin
         vld <= 1'b1;
         ch  <= ch_in;
      end else if (restore) begin
         vld <= 1'b0;
      end
   end
endmodule

// File: rtl/dma_prio_arb.sv
module dma_prio_arb #(
   parameter int N_CH       = 6,
   parameter int HP_IDX     = 0,
   parameter bit PREEMPT_EN = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [N_CH-1:0] ch_req_i,
   input  logic [N_CH-1:0] ch_en_i,
   input  logic            word_done_i,
   input  logic            burst_done_i,
   input  logic            hp_mode_i,
   input  logic            prio_rst_i,
   output logic [N_CH-1:0] grant_o,
   output logic            preempt_o,
   output logic            resume_o
);
   import dma_arb_pkg::*;

   localparam int            IW   = (N_CH > 1) ? $clog2(N_CH) : 1;
   localparam logic [IW-1:0] HP   = IW'(HP_IDX);
   localparam logic [IW-1:0] LAST = IW'(N_CH - 1);

   if (N_CH < 2) begin : g_bad_nch
      $error("dma_prio_arb: N_CH must be at least 2");
   end
   if (HP_IDX < 0 || HP_IDX >= N_CH) begin : g_bad_hp
      $error("dma_prio_arb: HP_IDX out of range");
   end

   function automatic logic [IW-1:0] nxt_ch(input logic [IW-1:0] x);
      return (x == LAST) ? '0 : x + 1'b1;
   endfunction

   arb_st_e       st_q, st_n;
   logic [IW-1:0] cur_q, cur_n;
   logic [IW-1:0] ptr_q, ptr_n;
   logic          rpend_q, rpend_n;
   logic          pre_q, pre_n;
   logic          res_q, res_n;

   logic [N_CH-1:0] elig;
   logic            rst_req, hp_win;
   logic [IW-1:0]   pick_start;
   logic            rr_found;
   logic [IW-1:0]   rr_idx;
   logic            sel_found;
   logic [IW-1:0]   sel_idx;
   logic            preempt_go, ret_go;
   logic            ctx_vld;
   logic [IW-1:0]   ctx_ch;

   assign elig      = ch_req_i & ch_en_i;
   assign rst_req   = rpend_q | prio_rst_i;
   assign hp_win    = hp_mode_i & elig[HP];
   assign sel_found = hp_win | rr_found;
   assign sel_idx   = hp_win ? HP : rr_idx;

   // The search starts at channel 1 after a priority reset, otherwise past the last served channel.
   always_comb begin
      if (rst_req)                pick_start = '0;
      else if (st_q == ARB_BUSY)  pick_start = nxt_ch(cur_q);
      else                        pick_start = ptr_q;
   end

   dma_arb_rr_pick #(.N_CH(N_CH)) u_pick (
      .elig  (elig),
      .start (pick_start),
      .found (rr_found),
      .idx   (rr_idx)
   );

   if (PREEMPT_EN) begin : g_pre
      assign preempt_go = (st_q == ARB_BUSY) && word_done_i && !burst_done_i &&
                          hp_win && (cur_q != HP) && !ctx_vld;
      dma_arb_ctx #(.N_CH(N_CH)) u_ctx (
         .clk     (clk),
         .rst_n   (rst_n),
         .save    (preempt_go),
         .restore (st_q == ARB_GAP),
         .ch_in   (cur_q),
         .vld     (ctx_vld),
         .ch      (ctx_ch)
      );
   end else begin : g_nopre
      assign preempt_go = 1'b0;
      assign ctx_vld    = 1'b0;
      assign ctx_ch     = '0;
   end

   assign ret_go = (st_q == ARB_BUSY) && burst_done_i && (cur_q == HP) && ctx_vld;

   always_comb begin
      st_n    = st_q;
      cur_n   = cur_q;
      ptr_n   = ptr_q;
      rpend_n = rst_req;
      pre_n   = 1'b0;
      res_n   = 1'b0;
      unique case (st_q)
         ARB_IDLE: begin
            rpend_n = 1'b0;
            ptr_n   = pick_start;
            if (sel_found) begin
               st_n  = ARB_BUSY;
               cur_n = sel_idx;
            end
         end
         ARB_BUSY: begin
            if (burst_done_i) begin
               if (ret_go) begin
                  st_n = ARB_GAP;
               end else begin
                  rpend_n = 1'b0;
                  ptr_n   = pick_start;
                  if (sel_found) cur_n = sel_idx;
                  else           st_n  = ARB_IDLE;
               end
            end else if (preempt_go) begin
               cur_n = HP;
               pre_n = 1'b1;
            end
         end
         ARB_GAP: begin
            st_n  = ARB_BUSY;
            cur_n = ctx_ch;
            res_n = 1'b1;
         end
         default: st_n = ARB_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ARB_IDLE;
         cur_q   <= '0;
         ptr_q   <= '0;
         rpend_q <= 1'b0;
         pre_q   <= 1'b0;
         res_q   <= 1'b0;
      end else begin
         st_q    <= st_n;
         cur_q   <= cur_n;
         ptr_q   <= ptr_n;
         rpend_q <= rpend_n;
         pre_q   <= pre_n;
         res_q   <= res_n;
      end
   end

   for (genvar g = 0; g < N_CH; g++) begin : g_gnt
      assign grant_o[g] = (st_q == ARB_BUSY) && (cur_q == IW'(g));
   end

   assign preempt_o = pre_q;
   assign resume_o  = res_q;
endmodule

// File: rtl/dma_prio_arb_chk.sv
module dma_prio_arb_chk #(
   parameter int N_CH = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic [N_CH-1:0] ch_req_i,
   input logic [N_CH-1:0] ch_en_i,
   input logic            word_done_i,
   input logic            burst_done_i,
   input logic            hp_mode_i,
   input logic            prio_rst_i,
   input logic [N_CH-1:0] grant_o,
   input logic            preempt_o,
   input logic            resume_o
);
   // R1
   grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_o));

   // R1
   grant_eligible_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(grant_o) == '0 && grant_o != '0 && !resume_o)
         |-> ((grant_o & $past(ch_req_i & ch_en_i)) != '0));

   // R3
   grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(grant_o) != '0 && !$past(word_done_i) && !$past(burst_done_i))
         |-> (grant_o == $past(grant_o)));

   // R5
   preempt_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      preempt_o |-> (grant_o[0] && $past(hp_mode_i) && $past(grant_o) != '0 && !$past(grant_o[0])));

   // R6
   hp_no_self_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(grant_o[0]) && !$past(burst_done_i)) |-> (grant_o[0] && !preempt_o));

   // R7
   resume_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      resume_o |-> ($past(grant_o) == '0 && grant_o != '0));

   // R4
   fair_no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(hp_mode_i) |-> !preempt_o);

   logic unused_ok;
   assign unused_ok = ^{prio_rst_i};
endmodule

bind dma_prio_arb dma_prio_arb_chk #(.N_CH(N_CH)) u_chk (.*);

// File: tb/dma_prio_arb_bench.sv
module dma_prio_arb_bench;
   localparam int CLK_P = 10;
   localparam int NC    = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NC-1:0] req = '0, en = '0;
   logic          wd = 1'b0, bd = 1'b0, hp = 1'b0, prst = 1'b0;
   logic [NC-1:0] gnt;
   logic          pre, res;

   int n_tests = 0;
   int n_fail  = 0;

   always #(CLK_P/2) clk = ~clk;

   dma_prio_arb u_dma_prio_arb (
      .clk          (clk),
      .rst_n        (rst_n),
      .ch_req_i     (req),
      .ch_en_i      (en),
      .word_done_i  (wd),
      .burst_done_i (bd),
      .hp_mode_i    (hp),
      .prio_rst_i   (prst),
      .grant_o      (gnt),
      .preempt_o    (pre),
      .resume_o     (res)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R10: outputs idle after reset
      chk("R10 grant", 32'(gnt), 32'h0);
      chk("R10 preempt", 32'(pre), 32'h0);
      chk("R10 resume", 32'(res), 32'h0);

      // Directed pre-emption sequence, multi-word bursts
      en = '1; hp = 1'b1; req = 6'b000100;
      tick(); chk("R10 R1 first grant ch3", 32'(gnt), 32'h04);
      wd = 1'b1; req = 6'b000101;
      tick(); chk("R5 preempt grant", 32'(gnt), 32'h01);
      chk("R5 preempt flag", 32'(pre), 32'h1);
      wd = 1'b1; bd = 1'b0;
      tick(); chk("R6 no self preempt", 32'(gnt), 32'h01);
      chk("R6 flag low", 32'(pre), 32'h0);
      bd = 1'b1; req = 6'b000000;
      tick(); chk("R7 gap cycle", 32'(gnt), 32'h0);
      chk("R7 gap resume low", 32'(res), 32'h0);
      wd = 1'b0; bd = 1'b0;
      tick(); chk("R7 resumed ch3 without request", 32'(gnt), 32'h04);
      chk("R7 resume flag", 32'(res), 32'h1);
      wd = 1'b1; bd = 1'b1; req = 6'b001010;
      tick(); chk("R8 pointer kept after preempt", 32'(gnt), 32'h08);
      wd = 1'b1; bd = 1'b0; prst = 1'b1; req = 6'b011010;
      tick(); chk("R9 R3 reset deferred", 32'(gnt), 32'h08);
      prst = 1'b0; bd = 1'b1; req = 6'b010010;
      tick(); chk("R9 reset applied at boundary", 32'(gnt), 32'h02);
      hp = 1'b0; bd = 1'b0; req = 6'b000011;
      tick(); chk("R4 fair mode no preempt", 32'(gnt), 32'h02);
      chk("R4 flag low", 32'(pre), 32'h0);
      bd = 1'b1;
      tick(); chk("R2 wrap to ch1", 32'(gnt), 32'h01);
      req = '0;
      tick(); chk("R1 idle when none eligible", 32'(gnt), 32'h0);
      tick(); chk("R11 strobes ignored while idle", 32'(gnt), 32'h0);
      chk("R11 no resume", 32'(res), 32'h0);

      // Exhaustive fair-order sweep, one-word bursts (R2, R4, R1)
      wd = 1'b1; bd = 1'b1;
      for (int m = 0; m < 2; m++) begin
         for (int r = 0; r < 64; r++) begin
            for (int e = 0; e < 64; e++) begin
               int eptr;
               logic [NC-1:0] el;
               hp = m[0]; req = '0; prst = 1'b1;
               tick();
               prst = 1'b0; req = 6'(r); en = 6'(e);
               el = 6'(r & e);
               eptr = 0;
               for (int s = 0; s < 8; s++) begin
                  int pk;
                  logic [NC-1:0] exp;
                  tick();
                  pk = -1;
                  if (hp && el[0]) pk = 0;
                  else begin
                     for (int k = NC - 1; k >= 0; k--) begin
                        int c;
                        c = (eptr + k) % NC;
                        if (el[c]) pk = c;
                     end
                  end
                  exp = (pk < 0) ? '0 : 6'(1 << pk);
                  if (pk >= 0) eptr = (pk + 1) % NC;
                  chk(hp ? "R4 R2 sweep hp" : "R2 R1 sweep fair", 32'(gnt), 32'(exp));
               end
            end
         end
      end
      req = '0;
      tick();
      summary();
   end
endmodule